// File: doc/BRIEF.md
# Load/Store Unit with Register-Zero Constant Path

This unit sits between the execute stage of a small 32-bit RISC core and a wait-stated memory bus. Every memory reference is formed from a base register value plus a 16-bit offset. The offset is always zero-extended, never sign-extended. The core presents one request at a time. The unit stalls the core by holding its ready low until the current access has been answered.

When the base register index is zero, the unit does not touch the bus. The zero-extended offset is taken as the operand and answered on the next cycle, so register zero works as a constant generator. Two merge operations shift the old destination value left and insert the low part of the operand: a halfword form (shift 16) and a byte form (shift 8). A pair of halfword merges through register zero builds any 32-bit constant. The same merges over memory data gather unaligned or packed fields.

The most significant address bit picks the memory region. The lower half is the fast dynamic RAM with 2 wait states. The upper half is the slow static RAM with 5 wait states. The unit counts the wait states itself and samples read data on the last wait cycle.

Top module: `lsu_core`

## Requirements
- R1: For a bus access, `mem_addr` equals `req_base_val` plus `req_offset` zero-extended to 32 bits, wrapping modulo 2^32. It is presented from the cycle after acceptance until the access ends.
- R2: A request whose `req_base_idx` is 0 makes no bus cycle (`mem_en` stays 0). The response comes in the cycle right after acceptance. For op LDW (2'b00) the response data is the zero-extended offset.
- R3: Op SHH (2'b10) returns `{req_dst_old[15:0], src[15:0]}`. Here src is the memory word, or the zero-extended offset when the base index is 0.
- R4: Op SHB (2'b11) returns `{req_dst_old[23:0], src[7:0]}`. Through register 0 this means bits 15:8 of the offset have no effect on the result.
- R5: An access with address bit 31 = 0 holds `mem_en` for 3 cycles. Its response is valid 3 cycles after the acceptance edge.
- R6: An access with address bit 31 = 1 holds `mem_en` for 6 cycles. Its response is valid 6 cycles after the acceptance edge.
- R7: `req_ready` is 0 while a bus access is outstanding. A request held valid during that time is taken only after the response, so at most one access is in flight and responses come back in request order.
- R8: A store (op STW, 2'b01) through register 0 is a no-op. There is no bus cycle and no write, and the response (data 0) comes the next cycle.
- R9: A store with a non-zero base index drives `mem_we` with `req_wdata` for the whole access and responds with data 0. A later LDW (2'b00) from the same address returns the stored word.
- R10: During reset `req_ready` is 1, and `rsp_valid`, `mem_en` and `mem_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Core presents a request |
| req_ready | output | 1 | Unit can take a request this cycle |
| req_op | input | 2 | 00 load word, 01 store word, 10 halfword merge, 11 byte merge |
| req_base_idx | input | 5 | Base register index; 0 selects the constant path |
| req_base_val | input | 32 | Base register contents |
| req_offset | input | 16 | Unsigned offset |
| req_dst_old | input | 32 | Current destination value, used by merges |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | One-cycle pulse with the result |
| rsp_data | output | 32 | Result to write back (0 for stores) |
| mem_en | output | 1 | Bus access in progress |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, sampled on the last wait cycle |

## Verification
The bench uses offsets with bit 15 set. A design that sign-extends would then put out an address 64 KiB too low, and read the wrong word. It sends byte merges through register 0 with a non-zero upper offset byte, which catches a unit that leaks offset bits 15:8 into the result. It stores through register 0 and then reads the target address back, which exposes a unit that writes the bus anyway. The scoreboard keeps the response cycle for each region and for a request queued behind a slow access. A miscounted wait, a response that comes too early, or a second access accepted while one is pending therefore shows up as a timing or ordering mismatch.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  parameter int unsigned XLEN   = 32;
  parameter int unsigned OFFW   = 16;
  localparam int unsigned HALFW = 16;
  localparam int unsigned BYTEW = 8;

  typedef enum logic [1:0] {
    OP_LDW = 2'b00,
    OP_STW = 2'b01,
    OP_SHH = 2'b10,
    OP_SHB = 2'b11
  } lsu_op_e;

  // unsigned widening of the offset
  function automatic logic [XLEN-1:0] widen_off(input logic [OFFW-1:0] off);
    return {{(XLEN-OFFW){1'b0}}, off};
  endfunction

  function automatic logic [XLEN-1:0] eff_addr(input logic [XLEN-1:0] base,
                                              input logic [OFFW-1:0] off);
    return base + widen_off(off);
  endfunction

  // write-back value for each op
  function automatic logic [XLEN-1:0] shift_merge(input lsu_op_e op,
                                                 input logic [XLEN-1:0] dst,
                                                 input logic [XLEN-1:0] src);
    logic [XLEN-1:0] r;
    case (op)
      OP_LDW:  r = src;
      OP_SHH:  r = {dst[XLEN-HALFW-1:0], src[HALFW-1:0]};
      OP_SHB:  r = {dst[XLEN-BYTEW-1:0], src[BYTEW-1:0]};
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
  import lsu_pkg::*;
#(
  parameter int unsigned IDXW       = 5,
  parameter int unsigned FAST_WAIT  = 2,
  parameter int unsigned SLOW_WAIT  = 5,
  parameter int unsigned REGION_BIT = XLEN-1,
  parameter int unsigned CNTW       = 3
) (
  input  logic [IDXW-1:0] base_idx,
  input  logic [XLEN-1:0] base_val,
  input  logic [OFFW-1:0] offset,
  output logic [XLEN-1:0] ea,
  output logic            use_imm,
  output logic [XLEN-1:0] imm_val,
  output logic [CNTW-1:0] wait_cnt
);

  localparam logic [CNTW-1:0] FAST_CNT = CNTW'(FAST_WAIT);
  localparam logic [CNTW-1:0] SLOW_CNT = CNTW'(SLOW_WAIT);

  always_comb begin
    ea       = eff_addr(base_val, offset);
    use_imm  = (base_idx == '0);
    imm_val  = widen_off(offset);
    wait_cnt = ea[REGION_BIT] ? SLOW_CNT : FAST_CNT;
  end

endmodule

// File: rtl/lsu_wait_ctr.sv
module lsu_wait_ctr #(
  parameter int unsigned CNTW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [CNTW-1:0] load_val,
  output logic            busy,
  output logic            done
);

  logic [CNTW-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      cnt  <= load_val;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  // R5/R6: the wait count steps down by one each cycle while busy
  a_r5_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> (busy && cnt == $past(cnt) - 1'b1));

  // R7: never reloaded while an access is pending
  a_r7_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);

  // R5/R6: the final wait cycle ends the access
  a_r6_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy || load);

endmodule

// File: rtl/lsu_merge.sv
module lsu_merge
  import lsu_pkg::*;
(
  input  lsu_op_e         op,
  input  logic [XLEN-1:0] dst_old,
  input  logic [XLEN-1:0] src,
  output logic [XLEN-1:0] result
);

  always_comb result = shift_merge(op, dst_old, src);

endmodule

// File: rtl/lsu_core.sv
module lsu_core
  import lsu_pkg::*;
#(
  parameter int unsigned IDXW      = 5,
  parameter int unsigned FAST_WAIT = 2,
  parameter int unsigned SLOW_WAIT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [IDXW-1:0]  req_base_idx,
  input  logic [XLEN-1:0]  req_base_val,
  input  logic [OFFW-1:0]  req_offset,
  input  logic [XLEN-1:0]  req_dst_old,
  input  logic [XLEN-1:0]  req_wdata,
  output logic             rsp_valid,
  output logic [XLEN-1:0]  rsp_data,
  output logic             mem_en,
  output logic             mem_we,
  output logic [XLEN-1:0]  mem_addr,
  output logic [XLEN-1:0]  mem_wdata,
  input  logic [XLEN-1:0]  mem_rdata
);

  localparam int unsigned MAX_WAIT = (FAST_WAIT > SLOW_WAIT) ? FAST_WAIT : SLOW_WAIT;
  localparam int unsigned CNTW     = $clog2(MAX_WAIT + 1);

  // named internal events
  logic            accept;
  logic            use_imm;
  logic            bus_start;
  logic            bus_busy;
  logic            bus_done;
  logic [XLEN-1:0] ea;
  logic [XLEN-1:0] imm_val;
  logic [CNTW-1:0] wait_cnt;

  lsu_op_e         op_q;
  logic [XLEN-1:0] dst_q;
  logic [XLEN-1:0] ea_q;
  logic [XLEN-1:0] wdata_q;

  lsu_op_e         mrg_op;
  logic [XLEN-1:0] mrg_dst;
  logic [XLEN-1:0] mrg_src;
  logic [XLEN-1:0] mrg_out;

  lsu_agen #(
    .IDXW      (IDXW),
    .FAST_WAIT (FAST_WAIT),
    .SLOW_WAIT (SLOW_WAIT),
    .REGION_BIT(XLEN-1),
    .CNTW      (CNTW)
  ) u_agen (
    .base_idx (req_base_idx),
    .base_val (req_base_val),
    .offset   (req_offset),
    .ea       (ea),
    .use_imm  (use_imm),
    .imm_val  (imm_val),
    .wait_cnt (wait_cnt)
  );

  assign req_ready = !bus_busy;
  assign accept    = req_valid && req_ready;
  assign bus_start = accept && !use_imm;

  lsu_wait_ctr #(.CNTW(CNTW)) u_wait (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (bus_start),
    .load_val(wait_cnt),
    .busy    (bus_busy),
    .done    (bus_done)
  );

  // accept and done never coincide: ready is low while busy
  always_comb begin
    if (bus_done) begin
      mrg_op  = op_q;
      mrg_dst = dst_q;
      mrg_src = mem_rdata;
    end else begin
      mrg_op  = lsu_op_e'(req_op);
      mrg_dst = req_dst_old;
      mrg_src = imm_val;
    end
  end

  lsu_merge u_merge (
    .op     (mrg_op),
    .dst_old(mrg_dst),
    .src    (mrg_src),
    .result (mrg_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_LDW;
      dst_q   <= '0;
      ea_q    <= '0;
      wdata_q <= '0;
    end else if (bus_start) begin
      op_q    <= lsu_op_e'(req_op);
      dst_q   <= req_dst_old;
      ea_q    <= ea;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= bus_done || (accept && use_imm);
      if (bus_done || (accept && use_imm)) rsp_data <= mrg_out;
    end
  end

  assign mem_en    = bus_busy;
  assign mem_we    = bus_busy && (op_q == OP_STW);
  assign mem_addr  = ea_q;
  assign mem_wdata = wdata_q;

  // R2: constant path answers next cycle without the bus
  a_r2_imm_next: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && use_imm) |=> (rsp_valid && !mem_en));

  // R1: bus address is base plus unsigned offset
  a_r1_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !use_imm) |=>
      (mem_en && mem_addr == $past(req_base_val) + {16'h0000, $past(req_offset)}));

  // R7: no request accepted while the bus is in use
  a_r7_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> !req_ready);

  // R9: address held stable through the access
  a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && $past(mem_en)) |-> $stable(mem_addr));

  // R8: store through register 0 writes nothing and returns zero
  a_r8_store_nop: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && use_imm && req_op == 2'b01) |=> (rsp_data == '0 && !mem_we));

  // R7: a response is never overlapped by a pending access start
  a_r7_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(mem_en)) |-> !mem_en || $past(accept));

endmodule

// File: tb/tb_lsu_core.sv
module tb_lsu_core;
  import lsu_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [1:0]  req_op;
  logic [4:0]  req_base_idx;
  logic [31:0] req_base_val;
  logic [15:0] req_offset;
  logic [31:0] req_dst_old;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        mem_en;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;

  always #10 clk = ~clk;

  lsu_core dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_base_idx(req_base_idx), .req_base_val(req_base_val),
    .req_offset(req_offset), .req_dst_old(req_dst_old), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // memory model
  logic [31:0] mem [logic [31:0]];

  function automatic logic [31:0] fill(input logic [31:0] a);
    return a ^ 32'hA5C3_0F1E;
  endfunction

  always @(posedge clk) if (mem_en && mem_we) mem[mem_addr] = mem_wdata;
  always @(negedge clk) mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : fill(mem_addr);

  // scoreboard
  typedef struct {
    logic [31:0] data;
    int          cyc;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  int  cyc    = 0;
  int  checks = 0;
  int  errors = 0;
  bit  ended  = 0;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sbq.size() == 0) begin
        chk(0, "R7 unexpected response", rsp_data, 32'h0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(rsp_data == e.data, e.tag, rsp_data, e.data);
        chk(cyc == e.cyc, {e.tag, " timing"}, cyc, e.cyc);
      end
    end
  end

  // driver: called at a negedge, returns at the negedge after acceptance
  task automatic send(input lsu_op_e op, input logic [4:0] idx, input logic [31:0] base,
                      input logic [15:0] off, input logic [31:0] dst, input logic [31:0] wd,
                      input int lat, input logic [31:0] exp, input string tag);
    req_valid    = 1'b1;
    req_op       = op;
    req_base_idx = idx;
    req_base_val = base;
    req_offset   = off;
    req_dst_old  = dst;
    req_wdata    = wd;
    while (!req_ready) @(negedge clk);
    sbq.push_back('{exp, cyc + 1 + lat, tag});
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (sbq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_sim();
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_op = 2'b00; req_base_idx = '0; req_base_val = '0;
    req_offset = '0; req_dst_old = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(req_ready == 1'b1, "R10 ready in reset", {31'b0, req_ready}, 32'h1);
    chk(rsp_valid == 1'b0, "R10 rsp_valid in reset", {31'b0, rsp_valid}, 32'h0);
    chk(mem_en == 1'b0 && mem_we == 1'b0, "R10 bus idle in reset", {30'b0, mem_en, mem_we}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9/R5 store to fast region
    send(OP_STW, 5'd3, 32'h0000_1000, 16'h0000, 32'h0, 32'hDEAD_BEEF, 3, 32'h0, "R9 store response");
    chk(mem_we && mem_wdata == 32'hDEAD_BEEF, "R9 write strobe", mem_wdata, 32'hDEAD_BEEF);
    drain();
    send(OP_LDW, 5'd4, 32'h0000_0F00, 16'h0100, 32'h0, 32'h0, 3, 32'hDEAD_BEEF, "R9 R5 load back");
    drain();

    // R1 offset with bit 15 set is not sign-extended
    send(OP_LDW, 5'd2, 32'h0000_2000, 16'h8004, 32'h0, 32'h0, 3, fill(32'h0000_A004), "R1 load data");
    chk(mem_addr == 32'h0000_A004, "R1 address", mem_addr, 32'h0000_A004);
    drain();

    // R6 slow region, R7 queued request
    send(OP_STW, 5'd5, 32'h8000_0040, 16'h0004, 32'h0, 32'h0BAD_F00D, 6, 32'h0, "R6 store");
    chk(req_ready == 1'b0, "R7 ready low while busy", {31'b0, req_ready}, 32'h0);
    send(OP_LDW, 5'd5, 32'h8000_0000, 16'h0044, 32'h0, 32'h0, 6, 32'h0BAD_F00D, "R6 R7 queued load");
    drain();

    // R2 constant path
    send(OP_LDW, 5'd0, 32'hFFFF_FFFF, 16'hBEEF, 32'h0, 32'h0, 0, 32'h0000_BEEF, "R2 immediate");
    chk(mem_en == 1'b0, "R2 no bus cycle", {31'b0, mem_en}, 32'h0);
    drain();

    // R3 halfword merges build a constant
    send(OP_SHH, 5'd0, 32'h0, 16'h1234, 32'h0, 32'h0, 0, 32'h0000_1234, "R3 merge high");
    send(OP_SHH, 5'd0, 32'h0, 16'h5678, 32'h0000_1234, 32'h0, 0, 32'h1234_5678, "R3 merge low");
    drain();
    send(OP_SHH, 5'd1, 32'h0000_1000, 16'h0000, 32'h1111_CAFE, 32'h0, 3, 32'hCAFE_BEEF, "R3 memory merge");
    drain();

    // R4 byte merges
    send(OP_SHB, 5'd0, 32'h0, 16'hFF5A, 32'h00AA_BBCC, 32'h0, 0, 32'hAABB_CC5A, "R4 immediate byte");
    drain();
    send(OP_SHB, 5'd1, 32'h0000_1000, 16'h0000, 32'h1122_3344, 32'h0, 3, 32'h2233_44EF, "R4 memory byte");
    drain();
    send(OP_SHB, 5'd6, 32'h8000_0044, 16'h0000, 32'h0, 32'h0, 6, 32'h0000_000D, "R4 R6 slow byte");
    drain();

    // R8 store through register 0
    send(OP_STW, 5'd0, 32'h0, 16'h1000, 32'h0, 32'h5555_5555, 0, 32'h0, "R8 store no-op");
    chk(mem_en == 1'b0, "R8 no bus cycle", {31'b0, mem_en}, 32'h0);
    drain();
    send(OP_LDW, 5'd7, 32'h0000_1000, 16'h0000, 32'h0, 32'h0, 3, 32'hDEAD_BEEF, "R8 memory untouched");
    drain();

    // R7 immediate held behind slow load
    send(OP_LDW, 5'd1, 32'h8000_0044, 16'h0000, 32'h0, 32'h0, 6, 32'h0BAD_F00D, "R7 slow load");
    chk(req_ready == 1'b0, "R7 stall", {31'b0, req_ready}, 32'h0);
    send(OP_LDW, 5'd0, 32'h0, 16'h0042, 32'h0, 32'h0, 0, 32'h0000_0042, "R7 immediate after stall");
    drain();

    finish_sim();
  end

endmodule